// File: doc/BRIEF.md
# DRAM refresh scheduler

This block keeps a one-bit-wide dynamic memory alive. The memory needs 256 row refreshes in every 4 ms window. A free-running tick timer counts system clock cycles and marks one refresh as owed every 4 ms / 256. A small counter holds the owed refreshes. While at least one is owed, the block requests the memory bus from the access controller.

Once the bus is granted, the block runs one refresh pulse for each owed refresh, back to back. Each pulse puts the refresh row on the address bus and drives the row strobe low. The row strobe low time and the precharge time are derived from the clock frequency. Every pulse is framed by precharge. The block then drops both its request and its bus ownership in the same cycle.

Two refresh styles can be selected at grant time:
- **Row-strobe-only refresh:** the column strobe stays high.
- **Hidden refresh:** the column strobe is held low for the whole ownership. This follows a read, so the read data stays on the output while the row strobe cycles.

A sticky flag records that the owed count ever reached its limit before service.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and after reset: ref_req=0, bus_own=0, ras_n=1, cas_n=1, owed_ovf=0, row_addr=0.
- R2: One refresh is owed every TICK_CYC = CLK_KHZ*PERIOD_US/(1000*ROWS) clock cycles. ref_req is first seen high TICK_CYC+1 cycles after reset is released.
- R3: bus_gnt has no effect while ref_req is low: bus_own stays 0 and ras_n stays 1.
- R4: In row-strobe-only mode (hidden_en=0 at grant), cas_n stays 1 throughout ownership. row_addr is stable on the cycle ras_n falls, and ras_n is never low without ownership.
- R5: Each refresh pulse holds ras_n low for exactly ceil(TRAS_NS/clock period) cycles. This is 18 cycles at 250 MHz.
- R6: ras_n is high for PRE_CYC cycles before the first pulse, between pulses and after the last pulse. PRE_CYC = max(ceil(TRP_NS/period), ceil(TRC_NS/period) - low cycles). This is 15 cycles at 250 MHz, giving a 132 ns pulse cycle.
- R7: With hidden_en=1 sampled at the grant cycle, cas_n is 0 on every cycle of ownership.
- R8: The row on row_addr at each falling ras_n is the previous refresh row plus one, modulo 256.
- R9: A single grant runs one refresh pulse for each owed refresh, back to back, without further grants.
- R10: The owed count saturates at OWED_MAX (8). After ten intervals without a grant, exactly 8 pulses follow.
- R11: owed_ovf goes to 1 when the owed count reaches OWED_MAX and stays 1 until reset. It stays 0 while fewer are owed.
- R12: bus_own implies ref_req. Both fall in the same cycle after the final precharge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hidden_en | input | 1 | Selects hidden refresh; sampled when the grant is accepted |
| bus_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Bus request, high while refreshes are owed or running |
| bus_own | output | 1 | Block drives the memory strobes and address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Refresh row address |
| owed_ovf | output | 1 | Sticky flag: owed count reached its limit |

## Verification
The refresh engine is driven with grants at different distances behind the tick:
- **Immediate grant:** one pulse, checked for exact low, precharge and address timing in both strobe styles.
- **Grant withheld for three intervals:** shows that owed refreshes accumulate and run under one grant, with no overflow.
- **Grant withheld past ten intervals:** separates saturation at eight from unbounded counting and proves the flag is sticky.

A long run of single-pulse grants carries the row counter through its wrap. A grant pulsed before any request shows that an unsolicited grant is ignored.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_KHZ   = 250000,
  parameter int PERIOD_US = 4000,
  parameter int ROWS      = 256,
  parameter int OWED_MAX  = 8,
  parameter int TRAS_NS   = 70,
  parameter int TRP_NS    = 50,
  parameter int TRC_NS    = 130,
  parameter int ROW_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hidden_en,
  input  logic             bus_gnt,
  output logic             ref_req,
  output logic             bus_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             owed_ovf
);
  localparam int TICK_CYC = CLK_KHZ * PERIOD_US / (1000 * ROWS);
  localparam int CYC_PS   = 1000000000 / CLK_KHZ;
  localparam int LO_CYC   = (TRAS_NS * 1000 + CYC_PS - 1) / CYC_PS;
  localparam int PRE_MIN  = (TRP_NS * 1000 + CYC_PS - 1) / CYC_PS;
  localparam int RC_CYC   = (TRC_NS * 1000 + CYC_PS - 1) / CYC_PS;
  localparam int PRE_CYC  = (RC_CYC - LO_CYC > PRE_MIN) ? RC_CYC - LO_CYC : PRE_MIN;
  localparam int PH_W     = $clog2((LO_CYC > PRE_CYC ? LO_CYC : PRE_CYC) + 1);
  localparam int TMR_W    = $clog2(TICK_CYC + 1);
  localparam int OWED_W   = $clog2(OWED_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PRE, S_ACT} st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [PH_W-1:0]  ph;
  logic [OWED_W-1:0] owed;
  logic [ROW_W-1:0] row;
  logic             hid;

  wire tick      = (tmr == TMR_W'(TICK_CYC - 1));
  wire owed_full = (owed == OWED_W'(OWED_MAX));
  wire act_end   = (st == S_ACT) && (ph == PH_W'(LO_CYC - 1));
  wire pre_end   = (st == S_PRE) && (ph == PH_W'(PRE_CYC - 1));
  wire [OWED_W-1:0] owed_nxt = owed + OWED_W'(tick && !owed_full) - OWED_W'(act_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      ph       <= '0;
      owed     <= '0;
      row      <= '0;
      hid      <= 1'b0;
      owed_ovf <= 1'b0;
    end else begin
      tmr      <= tick ? '0 : tmr + 1'b1;
      owed     <= owed_nxt;
      owed_ovf <= owed_ovf | (owed_nxt == OWED_W'(OWED_MAX));
      case (st)
        S_IDLE: if (owed != '0) st <= S_WAIT;
        S_WAIT: if (bus_gnt) begin
          st  <= S_PRE;
          ph  <= '0;
          hid <= hidden_en;
        end
        S_PRE: if (pre_end) begin
          ph <= '0;
          st <= (owed != '0) ? S_ACT : S_IDLE;
        end else ph <= ph + 1'b1;
        S_ACT: if (act_end) begin
          ph  <= '0;
          st  <= S_PRE;
          row <= row + 1'b1;
        end else ph <= ph + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ref_req  = (st != S_IDLE);
  assign bus_own  = (st == S_PRE) || (st == S_ACT);
  assign ras_n    = (st != S_ACT);
  assign cas_n    = !(bus_own && hid);
  assign row_addr = row;
endmodule

module dram_refresh_sched_chk #(
  parameter int ROW_W  = 8,
  parameter int LO_CYC = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic             bus_own,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             owed_ovf
);
  logic [15:0] lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) lo_cnt <= '0;
    else                 lo_cnt <= lo_cnt + 1'b1;
  end

  // R5
  ras_lo_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_cnt == 16'(LO_CYC));
  // R4
  ras_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> ras_n);
  // R4
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(row_addr));
  // R7
  cas_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && $past(bus_own)) |-> $stable(cas_n));
  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> row_addr == ROW_W'($past(row_addr) + 1'b1));
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_ovf |=> owed_ovf);
  // R12
  own_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> ref_req);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W), .LO_CYC(LO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .bus_own(bus_own), .ras_n(ras_n),
  .cas_n(cas_n), .row_addr(row_addr), .owed_ovf(owed_ovf));

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
  localparam int TICK = 500;
  localparam int LO   = 18;
  localparam int PRE  = 15;

  logic clk = 1'b0, rst_n = 1'b0, hidden_en = 1'b0, bus_gnt = 1'b0;
  logic ref_req, bus_own, ras_n, cas_n, owed_ovf;
  logic [7:0] row_addr;
  int checks = 0, fails = 0, exp_row = 0;

  always #2 clk = ~clk;

  dram_refresh_sched #(.CLK_KHZ(250000), .PERIOD_US(512)) uut (
    .clk(clk), .rst_n(rst_n), .hidden_en(hidden_en), .bus_gnt(bus_gnt),
    .ref_req(ref_req), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
    .row_addr(row_addr), .owed_ovf(owed_ovf));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1", "req/own/ras/cas/ovf", {ref_req, bus_own, ras_n, cas_n, owed_ovf}, 5'b00110);
    chk("R1", "row", row_addr, 0);
  endtask

  task automatic t_first_tick();
    int n = 0, bad = 0;
    rst_n = 1'b1;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 5) bus_gnt = 1'b1;
      if (n == 15) bus_gnt = 1'b0;
      if (n > 5 && n <= 15 && (bus_own || !ras_n)) bad++;
      if (n == 3) chk("R1", "state after release", {ref_req, bus_own, ras_n, cas_n}, 4'b0011);
      if (ref_req) break;
    end
    chk("R3", "grant without request", bad, 0);
    chk("R2", "first request cycle", n, TICK + 1);
  endtask

  task automatic run_burst(input int n, input logic hid, input string tag);
    int lo = 0, hi = 0, pulses = 0, cbad = 0;
    logic prev = 1'b1;
    hidden_en = hid;
    while (!ref_req) @(negedge clk);
    bus_gnt = 1'b1;
    @(negedge clk);
    chk("R9", "ownership after grant", bus_own, 1);
    while (bus_own) begin
      if (cas_n != !hid) cbad++;
      if (!ras_n) begin
        if (prev) begin
          chk("R6", "precharge before pulse", hi, PRE);
          chk("R8", "row at pulse", row_addr, exp_row);
          hi = 0;
        end
        lo++;
      end else begin
        if (!prev) begin
          chk("R5", "ras low width", lo, LO);
          lo = 0;
          pulses++;
          exp_row = (exp_row + 1) % 256;
        end
        hi++;
      end
      prev = ras_n;
      @(negedge clk);
    end
    bus_gnt = 1'b0;
    chk("R6", "final precharge", hi, PRE);
    chk("R12", "request dropped with ownership", ref_req, 0);
    chk(hid ? "R7" : "R4", "cas level mismatches", cbad, 0);
    chk(tag, "pulses in burst", pulses, n);
  endtask

  task automatic t_backlog();
    while (!ref_req) @(negedge clk);
    repeat (2 * TICK + 50) @(negedge clk);
    chk("R11", "no overflow at three owed", owed_ovf, 0);
    run_burst(3, 1'b0, "R9");
  endtask

  task automatic t_overflow();
    while (!ref_req) @(negedge clk);
    repeat (9 * TICK + 50) @(negedge clk);
    chk("R11", "overflow set", owed_ovf, 1);
    run_burst(8, 1'b0, "R10");
    repeat (3) @(negedge clk);
    chk("R11", "overflow sticky", owed_ovf, 1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 256; i++) run_burst(1, 1'b0, "R8");
    chk("R8", "row after full wrap", row_addr, exp_row);
  endtask

  initial begin
    t_reset();
    t_first_tick();
    run_burst(1, 1'b0, "R4");
    run_burst(1, 1'b1, "R7");
    t_backlog();
    t_overflow();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run not complete, got 190000 cycles expected fewer");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule